// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a single-word next-level memory port. It holds 256 lines of four 32-bit words each. The address is cut into a line tag, a line index, a word-in-line offset and an ignored byte offset. A lookup reads the stored tag and valid bit for the indexed line. A read hit returns the word in the same cycle. A write hit merges the enabled bytes into the line and marks the line dirty.

On a miss, `cpu_ready` stays low. If the victim line is dirty, its four words are first written to memory at consecutive word addresses. The refill then reads the requested word first and completes the processor access in the same cycle that word arrives. The remaining words of the line follow in wrapping order while the processor carries on. Write misses allocate the line: the fetched word is merged with the processor's enabled bytes and the line is installed dirty.

The requester holds `cpu_req` and all request fields stable until it sees `cpu_ready`. The memory side holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`. Each `mem_ack` completes one word.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid and clean. The first access to any address therefore misses, and its refill produces no memory write.
- R2: The address fields are as follows. Bits 31..12 are the tag, bits 11..4 select the line, bits 3..2 select the word, and bits 1..0 are ignored. A hit needs the line's valid bit set and its stored tag equal to bits 31..12. Two addresses with the same bits 11..4 and different tags evict each other.
- R3: A read hit raises `cpu_ready` in the cycle of the request, returns the stored word on `cpu_rdata`, and makes no memory transfer.
- R4: A write hit completes in the cycle of the request and makes no memory transfer. It updates only the bytes whose `cpu_be` bit is set, where `cpu_be[i]` covers data bits 8i+7..8i. It also marks the line dirty.
- R5: A refill reads four words from memory at `{tag, index, w, 00}`. The first read is the requested word w0. The next reads are w0+1, w0+2 and w0+3, wrapping modulo 4.
- R6: On a miss, `cpu_ready` rises in the same cycle as the `mem_ack` of the first refill word, and `cpu_rdata` then equals that word.
- R7: A write miss fetches the line, merges the enabled bytes into the requested word, and leaves the line dirty. The merged word is later written back when the line is evicted.
- R8: Before any refill read, a dirty victim is written back with four memory writes. Their addresses are `{old tag, index, 0..3, 00}`, in increasing order, and their data is the line's current content. `cpu_ready` stays low during these writes. A clean victim is dropped without writes.
- R9: While the rest of a line is still being filled, several cases apply. An access to an already received word of that line is served at once. An access to a word not yet received stalls until that word arrives. A hit to another line is served. A miss to any line stalls until the refill finishes, and its memory traffic comes after all refill reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current word transfer |

## Verification
Two events can fall in the same cycle. The first is a processor write hit on an already received word of the line being refilled. The second is the `mem_ack` that writes another word of that same line. The bench slows the memory response and then issues eight back-to-back write hits to the first word of a line whose refill is still running, so at least one of them lands on a fill cycle. The result is judged in three ways: the final read-back must show the last written value, the refilled words must carry the memory pattern, and the later eviction must write back exactly those four values.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_CRIT  = 2'd2,
      ST_REST  = 2'd3
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 256,
   parameter int IDX_W = 8,
   parameter int TAG_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic             lk_valid,
   output logic             lk_dirty,
   output logic [TAG_W-1:0] lk_tag,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [TAG_W-1:0] ins_tag,
   input  logic             ins_dirty,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx
);
   timeunit 1ns;
   timeprecision 100ps;

   if (LINES != (1 << IDX_W)) begin : g_bad_lines
      $error("dmc_tag_store: LINES must equal 2**IDX_W");
   end

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (ins_en) begin
            valid_q[ins_idx] <= 1'b1;
            dirty_q[ins_idx] <= ins_dirty;
         end
         if (mark_en) dirty_q[mark_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en) tag_q[ins_idx] <= ins_tag;
   end

   assign lk_valid = valid_q[lk_idx];
   assign lk_dirty = dirty_q[lk_idx];
   assign lk_tag   = tag_q[lk_idx];

   AST_MARK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      mark_en |-> valid_q[mark_idx]);  // R4
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int ADR_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic [ADR_W-1:0]    a_addr,
   output logic [DATA_W-1:0]   a_data,
   input  logic [ADR_W-1:0]    b_addr,
   output logic [DATA_W-1:0]   b_data,
   input  logic                f_en,
   input  logic [ADR_W-1:0]    f_addr,
   input  logic [DATA_W-1:0]   f_data,
   input  logic                w_en,
   input  logic [ADR_W-1:0]    w_addr,
   input  logic [DATA_W/8-1:0] w_be,
   input  logic [DATA_W-1:0]   w_data
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int BE_W  = DATA_W / 8;
   localparam int DEPTH = 1 << ADR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] w_mask;
   logic [DATA_W-1:0] w_old;

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      assign w_mask[8*i +: 8] = {8{w_be[i]}};
   end

   // a same-cycle fill of the same word is the base for the byte merge
   assign w_old = (f_en && f_addr == w_addr) ? f_data : mem_q[w_addr];

   always_ff @(posedge clk) begin
      if (f_en) mem_q[f_addr] <= f_data;
      if (w_en) mem_q[w_addr] <= (w_old & ~w_mask) | (w_data & w_mask);
   end

   assign a_data = mem_q[a_addr];
   assign b_data = mem_q[b_addr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 20,
   parameter int IDX_W  = 8,
   parameter int OFF_W  = 2,
   parameter int BOFF_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [TAG_W-1:0]       cpu_tag,
   input  logic [IDX_W-1:0]       cpu_idx,
   input  logic [OFF_W-1:0]       cpu_word,
   input  logic                   lk_valid,
   input  logic                   lk_dirty,
   input  logic [TAG_W-1:0]       lk_tag,
   input  logic                   mem_ack,
   output logic                   cpu_ready,
   output logic                   take_mem,
   output logic                   ins_en,
   output logic [IDX_W-1:0]       ins_idx,
   output logic [TAG_W-1:0]       ins_tag,
   output logic                   ins_dirty,
   output logic                   mark_en,
   output logic                   wr_en,
   output logic                   fill_en,
   output logic [IDX_W+OFF_W-1:0] fill_addr,
   output logic [IDX_W+OFF_W-1:0] ev_addr,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int LW = 1 << OFF_W;

   dmc_state_e       state_q;
   logic [TAG_W-1:0] m_tag_q, v_tag_q;
   logic [IDX_W-1:0] m_idx_q;
   logic [OFF_W-1:0] m_crit_q, cnt_q, cur_word;
   logic [LW-1:0]    fmask_q;
   logic             line_hit, word_ok, serve, hit, crit_done, last;

   assign line_hit  = lk_valid && (lk_tag == cpu_tag);
   assign word_ok   = !(state_q == ST_REST && cpu_idx == m_idx_q) || fmask_q[cpu_word];
   assign serve     = (state_q == ST_IDLE) || (state_q == ST_REST);
   assign hit       = cpu_req && serve && line_hit && word_ok;
   assign crit_done = (state_q == ST_CRIT) && mem_ack;
   assign cur_word  = m_crit_q + cnt_q;
   assign last      = (cnt_q == OFF_W'(LW - 1));

   assign cpu_ready = hit || crit_done;
   assign take_mem  = crit_done;
   assign mark_en   = hit && cpu_we;
   assign wr_en     = cpu_ready && cpu_we;
   assign ins_en    = crit_done;
   assign ins_idx   = m_idx_q;
   assign ins_tag   = m_tag_q;
   assign ins_dirty = cpu_we;
   assign fill_en   = mem_ack && (state_q == ST_CRIT || state_q == ST_REST);
   assign fill_addr = {m_idx_q, cur_word};
   assign ev_addr   = {m_idx_q, cnt_q};
   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_EVICT);
   assign mem_addr  = mem_we ? {v_tag_q, m_idx_q, cnt_q, {BOFF_W{1'b0}}}
                             : {m_tag_q, m_idx_q, cur_word, {BOFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         m_tag_q  <= '0;
         v_tag_q  <= '0;
         m_idx_q  <= '0;
         m_crit_q <= '0;
         cnt_q    <= '0;
         fmask_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_req && !line_hit) begin
                  m_tag_q  <= cpu_tag;
                  m_idx_q  <= cpu_idx;
                  m_crit_q <= cpu_word;
                  v_tag_q  <= lk_tag;
                  cnt_q    <= '0;
                  state_q  <= (lk_valid && lk_dirty) ? ST_EVICT : ST_CRIT;
               end
            end
            ST_EVICT: if (mem_ack) begin
               cnt_q <= cnt_q + OFF_W'(1);
               if (last) state_q <= ST_CRIT;
            end
            ST_CRIT: if (mem_ack) begin
               cnt_q   <= cnt_q + OFF_W'(1);
               fmask_q <= LW'(1) << cur_word;
               state_q <= ST_REST;
            end
            default: if (mem_ack) begin
               cnt_q             <= cnt_q + OFF_W'(1);
               fmask_q[cur_word] <= 1'b1;
               if (last) state_q <= ST_IDLE;
            end
         endcase
      end
   end

   AST_EVICT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_req && mem_we && mem_ack) && mem_we) |->
         mem_addr == $past(mem_addr) + ADDR_W'(1 << BOFF_W));  // R8
   AST_NO_READY_IN_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !cpu_ready);  // R8
   AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && !$past(mem_req && !mem_we)) |->
         mem_addr[BOFF_W +: OFF_W] == cpu_word);  // R5
   AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_req && !mem_we && mem_ack) && mem_req && !mem_we) |->
         mem_addr[BOFF_W +: OFF_W] == $past(mem_addr[BOFF_W +: OFF_W]) + OFF_W'(1));  // R5
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 256,
   parameter int LINE_WORDS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [DATA_W/8-1:0] cpu_be,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                cpu_ready,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_ack
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int BOFF_W = $clog2(DATA_W / 8);
   localparam int OFF_W  = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BOFF_W;

   if (DATA_W % 8 != 0 || (DATA_W / 8) != (1 << BOFF_W)) begin : g_bad_data
      $error("dmc_cache: DATA_W must be a power-of-two number of bytes");
   end
   if (LINE_WORDS < 2 || LINE_WORDS != (1 << OFF_W)) begin : g_bad_words
      $error("dmc_cache: LINE_WORDS must be a power of two, at least 2");
   end
   if (LINES < 2 || LINES != (1 << IDX_W)) begin : g_bad_lines
      $error("dmc_cache: LINES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dmc_cache: address too narrow for the geometry");
   end

   logic [TAG_W-1:0]       a_tag, lk_tag, ins_tag;
   logic [IDX_W-1:0]       a_idx, ins_idx;
   logic [OFF_W-1:0]       a_word;
   logic                   byte_sel_unused;
   logic                   lk_valid, lk_dirty, ins_en, ins_dirty, mark_en;
   logic                   take_mem, wr_en, fill_en;
   logic [IDX_W+OFF_W-1:0] fill_addr, ev_addr;
   logic [DATA_W-1:0]      hit_data;

   assign a_tag           = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx           = cpu_addr[BOFF_W+OFF_W +: IDX_W];
   assign a_word          = cpu_addr[BOFF_W +: OFF_W];
   assign byte_sel_unused = ^cpu_addr[BOFF_W-1:0];

   dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(a_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
      .ins_en(ins_en), .ins_idx(ins_idx), .ins_tag(ins_tag), .ins_dirty(ins_dirty),
      .mark_en(mark_en), .mark_idx(a_idx)
   );

   dmc_data_store #(.ADR_W(IDX_W + OFF_W), .DATA_W(DATA_W)) u_data (
      .clk(clk),
      .a_addr({a_idx, a_word}), .a_data(hit_data),
      .b_addr(ev_addr), .b_data(mem_wdata),
      .f_en(fill_en), .f_addr(fill_addr), .f_data(mem_rdata),
      .w_en(wr_en), .w_addr({a_idx, a_word}), .w_be(cpu_be), .w_data(cpu_wdata)
   );

   dmc_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
              .BOFF_W(BOFF_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(a_tag), .cpu_idx(a_idx),
      .cpu_word(a_word),
      .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
      .mem_ack(mem_ack),
      .cpu_ready(cpu_ready), .take_mem(take_mem),
      .ins_en(ins_en), .ins_idx(ins_idx), .ins_tag(ins_tag), .ins_dirty(ins_dirty),
      .mark_en(mark_en), .wr_en(wr_en), .fill_en(fill_en), .fill_addr(fill_addr),
      .ev_addr(ev_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
   );

   assign cpu_rdata = take_mem ? mem_rdata : hit_data;

   AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !take_mem) |-> cpu_req);  // R3
endmodule

// File: tb/dmc_cache_bench.sv
module dmc_cache_bench;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [3:0]  cpu_be = 4'h0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata, mem_addr, mem_wdata;
   logic        cpu_ready, mem_req, mem_we;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int total = 0, bad = 0;
   int mem_lat = 2;
   int wcnt = 0;
   logic [31:0] bmem [logic [31:0]];
   logic [31:0] shadow [logic [31:0]];
   logic        log_we [64];
   logic [31:0] log_addr [64];
   logic [31:0] log_data [64];
   int          log_n = 0;
   logic        last_ack;
   int          last_wait;

   always #2.5 clk = ~clk;

   dmc_cache u_dmc_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
   endfunction

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      if (bmem.exists(a)) return bmem[a];
      return pat(a);
   endfunction

   function automatic logic [31:0] exp_val(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      if (shadow.exists(w)) return shadow[w];
      return pat(w);
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [3:0] be,
                                         input logic [31:0] wd);
      logic [31:0] r;
      r = old;
      for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = wd[8*i +: 8];
      return r;
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   // next-level memory: one word per ack, ack after mem_lat idle cycles
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (rst_n && mem_req) begin
            if (wcnt >= mem_lat) begin
               wcnt = 0;
               mem_ack = 1'b1;
               if (log_n < 64) begin
                  log_we[log_n] = mem_we;
                  log_addr[log_n] = mem_addr;
                  log_data[log_n] = mem_we ? mem_wdata : mem_val(mem_addr);
                  log_n++;
               end
               if (mem_we) bmem[mem_addr] = mem_wdata;
               else mem_rdata = mem_val(mem_addr);
            end else wcnt++;
         end
      end
   end

   // called just after a falling edge; returns just after a falling edge
   task automatic cpu_op(input logic we, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
      last_wait = 0;
      #1;
      while (!cpu_ready && last_wait < 500) begin
         @(negedge clk); #1;
         last_wait++;
      end
      if (last_wait >= 500) chk("R9 access hung", 32'd0, 32'd1);
      rd = cpu_rdata;
      last_ack = mem_ack;
      if (we) shadow[{a[31:2], 2'b00}] = merge(exp_val(a), be, wd);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0, g = 0;
      while (q < 3 && g < 1000) begin
         @(negedge clk); #1;
         g++;
         if (!mem_req) q++; else q = 0;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 ready low after reset", 32'(cpu_ready), 32'd0);
      chk("R1 no memory request after reset", 32'(mem_req), 32'd0);
   endtask

   task automatic t_read_miss();
      logic [31:0] rd;
      log_n = 0;
      cpu_op(1'b0, 32'h0000_1238, 4'h0, '0, rd);
      chk("R6 read miss critical word data", rd, pat(32'h0000_1238));
      chk("R6 ready with critical ack", 32'(last_ack), 32'd1);
      chk("R1 first access stalls", 32'(last_wait > 0), 32'd1);
      wait_quiet();
      chk("R5 refill length", 32'(log_n), 32'd4);
      for (int k = 0; k < 4; k++) begin
         chk("R1 refill has no write-back", 32'(log_we[k]), 32'd0);
         chk("R5 wrapping refill address", log_addr[k],
             32'h0000_1230 + 32'(((2 + k) % 4) * 4));
      end
   endtask

   task automatic t_hits();
      logic [31:0] rd;
      log_n = 0;
      cpu_op(1'b0, 32'h0000_1230, 4'h0, '0, rd);
      chk("R3 read hit no stall", 32'(last_wait), 32'd0);
      chk("R3 read hit data", rd, exp_val(32'h0000_1230));
      cpu_op(1'b0, 32'h0000_1233, 4'h0, '0, rd);
      chk("R2 byte offset ignored", rd, exp_val(32'h0000_1230));
      chk("R2 byte offset hit", 32'(last_wait), 32'd0);
      cpu_op(1'b1, 32'h0000_1234, 4'b0101, 32'hAABB_CCDD, rd);
      chk("R4 write hit no stall", 32'(last_wait), 32'd0);
      cpu_op(1'b0, 32'h0000_1234, 4'h0, '0, rd);
      chk("R4 byte-enabled merge", rd, merge(pat(32'h0000_1234), 4'b0101, 32'hAABB_CCDD));
      repeat (3) @(negedge clk);
      chk("R3 hits make no memory traffic", 32'(log_n), 32'd0);
   endtask

   task automatic t_evict();
      logic [31:0] rd;
      log_n = 0;
      cpu_op(1'b0, 32'h0000_2234, 4'h0, '0, rd);
      chk("R2 same index new tag misses", 32'(last_wait > 0), 32'd1);
      chk("R6 data after eviction", rd, pat(32'h0000_2234));
      wait_quiet();
      chk("R8 eviction plus refill length", 32'(log_n), 32'd8);
      for (int k = 0; k < 4; k++) begin
         chk("R8 write-back is a write", 32'(log_we[k]), 32'd1);
         chk("R8 write-back address", log_addr[k], 32'h0000_1230 + 32'(k * 4));
         chk("R8 write-back data", log_data[k], exp_val(32'h0000_1230 + 32'(k * 4)));
         chk("R5 refill after write-back", log_addr[4 + k],
             32'h0000_2230 + 32'(((1 + k) % 4) * 4));
      end
      log_n = 0;
      cpu_op(1'b0, 32'h0000_1234, 4'h0, '0, rd);
      chk("R8 written-back data returns", rd, exp_val(32'h0000_1234));
      wait_quiet();
      chk("R8 clean victim dropped", 32'(log_n), 32'd4);
      chk("R8 clean victim no write", 32'(log_we[0]), 32'd0);
   endtask

   task automatic t_write_miss();
      logic [31:0] rd;
      log_n = 0;
      cpu_op(1'b1, 32'h0000_4010, 4'b1000, 32'h1122_3344, rd);
      chk("R7 write miss stalls", 32'(last_wait > 0), 32'd1);
      chk("R7 write miss ends with critical ack", 32'(last_ack), 32'd1);
      wait_quiet();
      cpu_op(1'b0, 32'h0000_4010, 4'h0, '0, rd);
      chk("R7 allocated word merged", rd, merge(pat(32'h0000_4010), 4'b1000, 32'h1122_3344));
      chk("R7 allocated line hits", 32'(last_wait), 32'd0);
      log_n = 0;
      cpu_op(1'b0, 32'h0000_5010, 4'h0, '0, rd);
      wait_quiet();
      chk("R7 allocated line is dirty", 32'(log_we[0]), 32'd1);
      chk("R7 merged word written back", log_data[0], exp_val(32'h0000_4010));
      chk("R7 eviction count", 32'(log_n), 32'd8);
   endtask

   task automatic t_overlap();
      logic [31:0] rd;
      mem_lat = 4;
      log_n = 0;
      cpu_op(1'b0, 32'h0000_7300, 4'h0, '0, rd);
      chk("R6 overlap critical word", rd, pat(32'h0000_7300));
      cpu_op(1'b0, 32'h0000_7304, 4'h0, '0, rd);
      chk("R9 unfilled word stalls", 32'(last_wait > 0), 32'd1);
      chk("R9 unfilled word data", rd, pat(32'h0000_7304));
      for (int k = 0; k < 8; k++) begin
         cpu_op(1'b1, 32'h0000_7300, 4'hF, 32'hF000_0000 + 32'(k), rd);
         chk("R9 write to filled word during refill", 32'(last_wait), 32'd0);
      end
      cpu_op(1'b0, 32'h0000_1234, 4'h0, '0, rd);
      chk("R9 other line hit during refill", rd, exp_val(32'h0000_1234));
      cpu_op(1'b0, 32'h0000_7300, 4'h0, '0, rd);
      chk("R9 last write kept", rd, 32'hF000_0007);
      cpu_op(1'b0, 32'h0000_730C, 4'h0, '0, rd);
      chk("R9 refilled tail word", rd, pat(32'h0000_730C));
      cpu_op(1'b0, 32'h0000_8300, 4'h0, '0, rd);
      chk("R9 miss after refill data", rd, pat(32'h0000_8300));
      wait_quiet();
      chk("R9 traffic count", 32'(log_n), 32'd12);
      for (int k = 0; k < 4; k++) begin
         chk("R9 refill reads first", log_addr[k], 32'h0000_7300 + 32'(k * 4));
         chk("R9 refill read kind", 32'(log_we[k]), 32'd0);
         chk("R8 overlap write-back data", log_data[4 + k],
             exp_val(32'h0000_7300 + 32'(k * 4)));
      end
      chk("R9 next miss after write-back", log_addr[8], 32'h0000_8300);
      mem_lat = 2;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      @(negedge clk);
      t_read_miss();
      t_hits();
      t_evict();
      t_write_miss();
      t_overlap();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule